// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns three supply-level comparator flags into the control signals a processor core needs while its supply sags, fails and returns. The flags say that the supply is under the warning threshold, under the lowest level at which the core may run, and under the level at which the battery must take over. The flags arrive already synchronized. Each one is passed through a stability filter before the sequencer acts on it.

While the supply sits between the warning and minimum thresholds, the core keeps running. If the warning is enabled, it gets one interrupt request carrying the fixed vector address 0x2B. Below the minimum level, the core is held in reset and the memory strobes are forced inactive. Below the battery level, battery select is also raised. When the supply recovers past the minimum level, reset stays asserted for a fixed 21504 clocks before the core is released. The same delay applies after a cold reset of the block.

Top module: `pwrfail_seq`

## Requirements
- R1: While rst_n is low, cpu_reset and strobe_inhibit are 1, and bat_sel, pfw_irq and pfw_vec are 0.
- R2: After rst_n goes high with all three flags low, cpu_reset falls on exactly the 21504th rising clock edge, counting the first edge after release as edge 1.
- R3: A flag change is acted on only after the raw input has held the new value for FILT_LEN (default 4) consecutive clock edges. A warning pulse shorter than that raises no interrupt.
- R4: With warn_en at 1 and the core running, a rise of sup_below_warn that is held raises pfw_irq on edge FILT_LEN+1, counted from the change. pfw_vec reads 8'h2B while pfw_irq is 1, and cpu_reset stays 0.
- R5: With warn_en at 0, a warning crossing raises no interrupt.
- R6: pfw_irq stays set until a one-cycle pulse on warn_ack clears it. It does not fire again while the warning persists. It fires again on the next crossing from clear to warning.
- R7: Once sup_below_min has held for FILT_LEN edges, the next edge sets cpu_reset and strobe_inhibit, and pfw_irq is cleared. The warning flag does not change this.
- R8: When sup_below_min clears (battery flag clear), cpu_reset falls exactly FILT_LEN+1+21504 edges after the change.
- R9: A held sup_below_bat sets bat_sel and keeps cpu_reset. bat_sel falls FILT_LEN+1 edges after the flag clears, and the power-on delay then follows.
- R10: A return below the minimum level during the power-on delay puts the sequencer back in reset. The full delay restarts from the next recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_below_warn | input | 1 | Supply under warning threshold (synchronized) |
| sup_below_min | input | 1 | Supply under minimum operating level (synchronized) |
| sup_below_bat | input | 1 | Supply under battery switch-over level (synchronized) |
| warn_en | input | 1 | Enable for the warning interrupt |
| warn_ack | input | 1 | Clears a pending warning interrupt |
| cpu_reset | output | 1 | Holds the processor core in reset |
| strobe_inhibit | output | 1 | Forces chip enables and read/write strobe to inactive high |
| bat_sel | output | 1 | Selects the battery supply |
| pfw_irq | output | 1 | Power-fail warning interrupt request |
| pfw_vec | output | 8 | Interrupt vector address, 8'h2B while pfw_irq is set |

## Verification
The assertions check the following on every cycle:
- a filtered flag only takes a value that its raw input held on the previous edge;
- a filtered minimum or battery flag forces the matching state on the next edge;
- the interrupt is sticky until acknowledged, is only ever set while enabled, and always shows the right vector;
- reset is released only from a completed power-on count.

The exact lengths of the power-on and recovery delays, the rejection of short glitches, the single firing per crossing, and the restart of the delay after a relapse can only be shown by the bench's timed scenarios.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_WARN   = 3'd1,
    ST_RESET  = 3'd2,
    ST_BACKUP = 3'd3,
    ST_PORW   = 3'd4
  } pfs_state_t;

  localparam int FLAG_WARN = 0;
  localparam int FLAG_MIN  = 1;
  localparam int FLAG_BAT  = 2;
  localparam int NFLAGS    = 3;

  // states in which the core must not execute
  function automatic logic core_held(input pfs_state_t st);
    return (st == ST_RESET) || (st == ST_BACKUP) || (st == ST_PORW);
  endfunction

  // next state from filtered levels; battery outranks minimum, minimum outranks warning
  function automatic pfs_state_t next_state(input pfs_state_t st,
                                            input logic f_warn,
                                            input logic f_min,
                                            input logic f_bat,
                                            input logic por_done);
    pfs_state_t nx;
    nx = st;
    if (f_bat) begin
      nx = ST_BACKUP;
    end else if (f_min) begin
      nx = ST_RESET;
    end else begin
      case (st)
        ST_NORMAL: nx = f_warn ? ST_WARN : ST_NORMAL;
        ST_WARN:   nx = f_warn ? ST_WARN : ST_NORMAL;
        ST_RESET:  nx = ST_PORW;
        ST_BACKUP: nx = ST_PORW;
        ST_PORW:   nx = por_done ? (f_warn ? ST_WARN : ST_NORMAL) : ST_PORW;
        default:   nx = ST_PORW;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/pfs_filter.sv
module pfs_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_q;
  logic          differ;
  logic          accept;

  assign differ = (raw_i != filt_o);
  assign accept = differ && (run_q == CW'(FILT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_o <= 1'b0;
    end else if (accept) begin
      run_q  <= '0;
      filt_o <= raw_i;
    end else if (differ) begin
      run_q  <= run_q + 1'b1;
    end else begin
      run_q  <= '0;
    end
  end

  // R3: a new filtered value must equal what the raw input carried
  a_r3_filt_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_o) |-> ($past(raw_i) == filt_o));

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(FILT_LEN));

endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
  parameter int POR_CLKS = 21504
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(POR_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || done_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: leaving the count state always restarts from zero
  a_r10_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       f_warn,
  input  logic       f_min,
  input  logic       f_bat,
  input  logic       por_done,
  output pfs_state_t state_o
);
  pfs_state_t state_q;

  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PORW;
    else        state_q <= next_state(state_q, f_warn, f_min, f_bat, por_done);
  end

  // R9: battery level wins over everything
  a_r9_bat_forces_backup: assert property (@(posedge clk) disable iff (!rst_n)
    f_bat |=> (state_q == ST_BACKUP));

  // R7: minimum level forces reset regardless of warning
  a_r7_min_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (f_min && !f_bat) |=> (state_q == ST_RESET));

  // R8: recovery from reset goes through the power-on wait
  a_r8_reset_to_porw: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET && !f_min && !f_bat) |=> (state_q == ST_PORW));

  a_r2_porw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PORW && !por_done && !f_min && !f_bat) |=> (state_q == ST_PORW));

endmodule

// File: rtl/pfs_irq.sv
module pfs_irq #(
  parameter logic [7:0] VEC_ADDR = 8'h2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       f_warn,
  input  logic       running_i,
  input  logic       en_i,
  input  logic       ack_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic [7:0] vec_o,
  output logic       warn_edge_o
);
  logic warn_prev_q;
  logic pend_q;
  logic fire;

  assign warn_edge_o = f_warn && !warn_prev_q;
  assign fire        = warn_edge_o && en_i && running_i;
  assign irq_o       = pend_q;
  assign vec_o       = pend_q ? VEC_ADDR : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_prev_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      warn_prev_q <= f_warn;
      if (clr_i)      pend_q <= 1'b0;
      else if (fire)  pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  // R6: request is held until acknowledged
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i && !clr_i) |=> pend_q);

  // R5: only an enabled crossing sets the request
  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_i));

  // R6: a set is always caused by a new crossing
  a_r6_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(warn_edge_o));

endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
  import pfs_pkg::*;
#(
  parameter int         FILT_LEN = 4,
  parameter int         POR_CLKS = 21504,
  parameter logic [7:0] VEC_ADDR = 8'h2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_below_warn,
  input  logic       sup_below_min,
  input  logic       sup_below_bat,
  input  logic       warn_en,
  input  logic       warn_ack,
  output logic       cpu_reset,
  output logic       strobe_inhibit,
  output logic       bat_sel,
  output logic       pfw_irq,
  output logic [7:0] pfw_vec
);
  logic [NFLAGS-1:0] raw_flags;
  logic [NFLAGS-1:0] filt_flags;
  logic              por_run;
  logic              por_done;
  logic              core_running;
  logic              warn_edge;
  pfs_state_t        state;

  assign raw_flags[FLAG_WARN] = sup_below_warn;
  assign raw_flags[FLAG_MIN]  = sup_below_min;
  assign raw_flags[FLAG_BAT]  = sup_below_bat;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_filt
    pfs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_flags[g]),
      .filt_o (filt_flags[g])
    );
  end

  pfs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .f_warn   (filt_flags[FLAG_WARN]),
    .f_min    (filt_flags[FLAG_MIN]),
    .f_bat    (filt_flags[FLAG_BAT]),
    .por_done (por_done),
    .state_o  (state)
  );

  assign por_run = (state == ST_PORW);

  pfs_por_timer #(.POR_CLKS(POR_CLKS)) u_por (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (por_run),
    .done_o (por_done)
  );

  assign core_running = (state == ST_NORMAL);

  pfs_irq #(.VEC_ADDR(VEC_ADDR)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .f_warn      (filt_flags[FLAG_WARN]),
    .running_i   (core_running),
    .en_i        (warn_en),
    .ack_i       (warn_ack),
    .clr_i       (core_held(state)),
    .irq_o       (pfw_irq),
    .vec_o       (pfw_vec),
    .warn_edge_o (warn_edge)
  );

  assign cpu_reset      = core_held(state);
  assign strobe_inhibit = core_held(state);
  assign bat_sel        = (state == ST_BACKUP);

  // R2/R8: reset is only released at the end of a full power-on count
  a_r2_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset) |-> $past(por_done));

  // R4: vector is presented with every request
  a_r4_vector_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pfw_irq |-> (pfw_vec == VEC_ADDR));

  // R7: no request survives into reset
  a_r7_no_irq_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset) |=> !pfw_irq);

  // R9: battery select only with the core held
  a_r9_bat_implies_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> cpu_reset);

endmodule

// File: tb/pwrfail_seq_tb.sv
module pwrfail_seq_tb;
  localparam int FILT = 4;
  localparam int POR  = 21504;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_warn = 1'b0, s_min = 1'b0, s_bat = 1'b0;
  logic w_en = 1'b0, w_ack = 1'b0;
  logic cpu_reset, strobe_inhibit, bat_sel, pfw_irq;
  logic [7:0] pfw_vec;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwrfail_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .sup_below_warn(s_warn), .sup_below_min(s_min), .sup_below_bat(s_bat),
    .warn_en(w_en), .warn_ack(w_ack),
    .cpu_reset(cpu_reset), .strobe_inhibit(strobe_inhibit), .bat_sel(bat_sel),
    .pfw_irq(pfw_irq), .pfw_vec(pfw_vec)
  );

  // flags {warn,min,bat,en} then expected {reset,bat_sel,irq}
  typedef struct packed {
    logic w; logic m; logic b; logic en;
    logic xr; logic xb; logic xi;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{w:1'b1, m:1'b0, b:1'b0, en:1'b1, xr:1'b0, xb:1'b0, xi:1'b1},
    '{w:1'b1, m:1'b1, b:1'b0, en:1'b1, xr:1'b1, xb:1'b0, xi:1'b0},
    '{w:1'b1, m:1'b1, b:1'b1, en:1'b1, xr:1'b1, xb:1'b1, xi:1'b0},
    '{w:1'b1, m:1'b1, b:1'b0, en:1'b1, xr:1'b1, xb:1'b0, xi:1'b0},
    '{w:1'b0, m:1'b0, b:1'b0, en:1'b1, xr:1'b1, xb:1'b0, xi:1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (cpu_reset && n < 40000);
  endtask

  task automatic ack_pulse();
    w_ack = 1'b1;
    step(1);
    w_ack = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    // R1 reset state
    step(3);
    chk("R1 cpu_reset", cpu_reset, 1);
    chk("R1 strobe_inhibit", strobe_inhibit, 1);
    chk("R1 bat_sel", bat_sel, 0);
    chk("R1 irq", pfw_irq, 0);
    chk("R1 vec", pfw_vec, 0);

    // R2 power-on delay
    rst_n = 1'b1;
    count_release(n);
    chk("R2 por edges", n, POR);
    chk("R2 strobe released", strobe_inhibit, 0);

    // R3 short glitch rejected
    w_en = 1'b1;
    s_warn = 1'b1;
    step(FILT - 1);
    s_warn = 1'b0;
    step(10);
    chk("R3 glitch irq", pfw_irq, 0);

    // R5 disabled warning
    w_en = 1'b0;
    s_warn = 1'b1;
    step(FILT + 3);
    chk("R5 irq disabled", pfw_irq, 0);
    chk("R5 core runs", cpu_reset, 0);
    s_warn = 1'b0;
    step(FILT + 2);

    // R4 timing and vector
    w_en = 1'b1;
    s_warn = 1'b1;
    step(FILT);
    chk("R4 irq early", pfw_irq, 0);
    step(1);
    chk("R4 irq raised", pfw_irq, 1);
    chk("R4 vector", pfw_vec, 8'h2B);
    chk("R4 core runs", cpu_reset, 0);

    // R6 sticky, ack, no refire, refire on new crossing
    step(20);
    chk("R6 held", pfw_irq, 1);
    ack_pulse();
    chk("R6 acked", pfw_irq, 0);
    step(20);
    chk("R6 no refire", pfw_irq, 0);
    s_warn = 1'b0;
    step(FILT + 2);
    s_warn = 1'b1;
    step(FILT + 1);
    chk("R6 refire", pfw_irq, 1);
    ack_pulse();
    s_warn = 1'b0;
    step(FILT + 2);

    // table walk: R7 / R9 transitions
    foreach (TBL[i]) begin
      s_warn = TBL[i].w; s_min = TBL[i].m; s_bat = TBL[i].b; w_en = TBL[i].en;
      step(FILT + 2);
      chk($sformatf("R7 table%0d reset", i), cpu_reset, TBL[i].xr);
      chk($sformatf("R9 table%0d bat_sel", i), bat_sel, TBL[i].xb);
      chk($sformatf("R7 table%0d irq", i), pfw_irq, TBL[i].xi);
    end
    count_release(n);
    chk("R8 table release", cpu_reset, 0);

    // R7 exact entry, R8 exact recovery
    s_min = 1'b1;
    step(FILT);
    chk("R7 not yet", cpu_reset, 0);
    step(1);
    chk("R7 reset", cpu_reset, 1);
    chk("R7 strobes", strobe_inhibit, 1);
    s_min = 1'b0;
    count_release(n);
    chk("R8 recovery edges", n, FILT + 1 + POR);

    // R10 relapse during delay restarts it
    s_min = 1'b1;
    step(FILT + 2);
    s_min = 1'b0;
    step(1000);
    chk("R10 still waiting", cpu_reset, 1);
    s_min = 1'b1;
    step(FILT + 2);
    chk("R10 back in reset", cpu_reset, 1);
    s_min = 1'b0;
    count_release(n);
    chk("R10 full delay", n, FILT + 1 + POR);

    // R9 battery exit timing
    s_min = 1'b1; s_bat = 1'b1;
    step(FILT + 2);
    chk("R9 bat_sel on", bat_sel, 1);
    s_min = 1'b0; s_bat = 1'b0;
    step(FILT);
    chk("R9 bat_sel held", bat_sel, 1);
    step(1);
    chk("R9 bat_sel off", bat_sel, 0);
    chk("R9 reset kept", cpu_reset, 1);
    count_release(n);
    chk("R9 por after battery", n, POR);

    summary();
  end
endmodule